// File: doc/BRIEF.md
# Soft Reset Sequencer with PHY Clock Supervision

This block carries out a reset requested by software. The host sets a self-clearing start bit in a single 32-bit control register. Before the reset is allowed to finish, the block confirms that the receive clock and the transmit clock from the PHY are both toggling. Each PHY clock drives a toggle flop. That flop is synchronised into the system clock domain and watched for edges. If both clocks show activity within the check window, the block drives a fixed-length reset pulse to the MAC control register bank and to the system register bank. It also clears the sticky transmit and receive error flags. If either clock stays silent for the whole window, the block abandons the reset and sets a sticky timeout bit.

Host writes are ignored after a hardware reset until the host has read the register once. The same register shows the bus-width strap as a read-only bit and carries a fixed bit that always reads as one.

Register bit layout: bit 0 is the start/busy bit, bit 8 is the timeout bit, bit 16 is the bus-width strap, and bit 31 is the fixed one. All other bits read as 0.

Top module: `swrst_ctrl`

## Requirements
- R1: After hardware reset, the register reads 0x8000_0000 with bit 16 equal to `strap_wide`, and `mac_rst`, `sys_rst`, `err_tx` and `err_rx` are all low.
- R2: Once a read has been done, writing a 1 to bit 0 starts a soft reset. Bit 0 reads 1 from the cycle after the write until the operation ends, and then returns to 0 without any host action.
- R3: When both PHY clocks are active, `mac_rst` and `sys_rst` go high together for exactly 4 consecutive system clock cycles, and the operation ends when the pulse ends.
- R4: When either PHY clock is idle, no reset pulse is produced. Bit 0 stays 1 for exactly 256 cycles, after which bit 8 (timeout) is set.
- R5: The timeout bit stays set through further failed attempts and is cleared only when a later soft reset completes.
- R6: A completed soft reset clears `err_tx` and `err_rx`, which are otherwise set by their set inputs and held. A timed-out attempt leaves them unchanged.
- R7: Host writes after a hardware reset have no effect until the first `host_rd` strobe.
- R8: Bit 16 always follows `strap_wide` and bit 31 always reads 1. Writes to either bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read value |
| strap_wide | input | 1 | Bus-width strap (1 = 32-bit, 0 = 16-bit) |
| phy_rx_clk | input | 1 | PHY receive clock |
| phy_tx_clk | input | 1 | PHY transmit clock |
| err_tx_set | input | 1 | Sets the transmit error flag |
| err_rx_set | input | 1 | Sets the receive error flag |
| err_tx | output | 1 | Sticky transmit error flag |
| err_rx | output | 1 | Sticky receive error flag |
| mac_rst | output | 1 | Reset pulse to the MAC control register bank |
| sys_rst | output | 1 | Reset pulse to the system register bank |

## Verification
The bench stops each PHY clock alone and then both together, and checks that the busy window lasts exactly 256 cycles with no pulse. A design that accepts one active clock would wrongly complete, and one with an off-by-one window would show 255 or 257 cycles. It checks that the timeout bit survives a second failed attempt and clears only after a good reset, which catches a bit that is cleared on every new request. It issues a write before any read and a write to the strap bit, and confirms at the register and reset outputs that neither has any effect. It also confirms that the error flags survive a timed-out attempt but not a completed one.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  localparam int REG_W    = 32;
  localparam int BIT_GO   = 0;
  localparam int BIT_TMO  = 8;
  localparam int BIT_WIDE = 16;
  localparam int BIT_ONE  = 31;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_PULSE = 2'd2
  } srst_st_e;
endpackage

// File: rtl/clk_act_det.sv
module clk_act_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_clk,
  output logic edge_o
);
  logic          tgl, tgl_nxt;
  logic [SYNC:0] sh, sh_nxt;

  // toggle flop in the PHY clock domain
  assign tgl_nxt = ~tgl;
  always_ff @(posedge phy_clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= tgl_nxt;
  end

  // synchroniser plus one history stage in the system domain
  assign sh_nxt = {sh[SYNC-1:0], tgl};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= sh_nxt;
  end

  assign edge_o = sh[SYNC] ^ sh[SYNC-1];
endmodule

// File: rtl/srst_fsm.sv
module srst_fsm
  import swrst_pkg::*;
#(
  parameter int TMO   = 256,
  parameter int PULSE = 4,
  parameter int NCLK  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NCLK-1:0] clk_edge,
  output logic            busy,
  output logic            rst_pulse,
  output logic            timeout
);
  localparam int CW = $clog2(TMO + PULSE);

  srst_st_e        st, st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [NCLK-1:0] seen, seen_n;
  logic            tmo_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    seen_n = seen;
    tmo_n  = timeout;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          st_n   = ST_CHECK;
          cnt_n  = '0;
          seen_n = '0;
        end
      end
      ST_CHECK: begin
        seen_n = seen | clk_edge;
        if (&seen_n) begin
          st_n  = ST_PULSE;
          cnt_n = '0;
        end else if (cnt == CW'(TMO - 1)) begin
          st_n  = ST_IDLE;
          tmo_n = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_PULSE: begin
        if (cnt == CW'(PULSE - 1)) begin
          st_n  = ST_IDLE;
          tmo_n = 1'b0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      seen    <= '0;
      timeout <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      seen    <= seen_n;
      timeout <= tmo_n;
    end
  end

  assign busy      = (st != ST_IDLE);
  assign rst_pulse = (st == ST_PULSE);

  p_pulse_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |=> rst_pulse);
  p_pulse_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pulse && cnt == CW'(PULSE - 1)) |=> !rst_pulse && !busy);
  p_window_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHECK) |-> (cnt < CW'(TMO)));
  p_tmo_from_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> ($past(st) == ST_CHECK) && !rst_pulse);
  p_tmo_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout) |-> $past(rst_pulse));
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int TMO_CYC     = 256,
  parameter int PULSE_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             strap_wide,
  input  logic             phy_rx_clk,
  input  logic             phy_tx_clk,
  input  logic             err_tx_set,
  input  logic             err_rx_set,
  output logic             err_tx,
  output logic             err_rx,
  output logic             mac_rst,
  output logic             sys_rst
);
  localparam int NCLK = 2;

  logic [NCLK-1:0] phy_clks, clk_edge;
  logic            busy, rst_pulse, timeout;
  logic            rd_seen, rd_seen_n;
  logic            err_tx_n, err_rx_n;
  logic            start;

  assign phy_clks = {phy_tx_clk, phy_rx_clk};

  for (genvar g = 0; g < NCLK; g++) begin : g_det
    clk_act_det #(.SYNC(SYNC_STAGES)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .phy_clk(phy_clks[g]),
      .edge_o (clk_edge[g])
    );
  end

  // writes are accepted only after the first read since hardware reset
  assign start = host_wr && rd_seen && host_wdata[BIT_GO] && !busy;

  srst_fsm #(.TMO(TMO_CYC), .PULSE(PULSE_CYC), .NCLK(NCLK)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .clk_edge (clk_edge),
    .busy     (busy),
    .rst_pulse(rst_pulse),
    .timeout  (timeout)
  );

  always_comb begin
    rd_seen_n = rd_seen | host_rd;
    err_tx_n  = rst_pulse ? 1'b0 : (err_tx | err_tx_set);
    err_rx_n  = rst_pulse ? 1'b0 : (err_rx | err_rx_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen <= 1'b0;
      err_tx  <= 1'b0;
      err_rx  <= 1'b0;
    end else begin
      rd_seen <= rd_seen_n;
      err_tx  <= err_tx_n;
      err_rx  <= err_rx_n;
    end
  end

  always_comb begin
    host_rdata           = '0;
    host_rdata[BIT_GO]   = busy;
    host_rdata[BIT_TMO]  = timeout;
    host_rdata[BIT_WIDE] = strap_wide;
    host_rdata[BIT_ONE]  = 1'b1;
  end

  assign mac_rst = rst_pulse;
  assign sys_rst = rst_pulse;

  p_wr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_seen && !busy) |=> !busy);
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mac_rst |=> (!err_tx && !err_rx));
endmodule

// File: tb/sim_swrst_ctrl.sv
`timescale 1ns/1ps
module sim_swrst_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        strap_wide = 1'b1;
  logic        phy_rx_clk = 1'b0, phy_tx_clk = 1'b0;
  logic        rx_on = 1'b1, tx_on = 1'b1;
  logic        err_tx_set = 1'b0, err_rx_set = 1'b0;
  logic        err_tx, err_rx, mac_rst, sys_rst;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;
  always begin #20; if (rx_on) phy_rx_clk = ~phy_rx_clk; end
  always begin #17; if (tx_on) phy_tx_clk = ~phy_tx_clk; end

  swrst_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .strap_wide(strap_wide),
    .phy_rx_clk(phy_rx_clk), .phy_tx_clk(phy_tx_clk),
    .err_tx_set(err_tx_set), .err_rx_set(err_rx_set),
    .err_tx(err_tx), .err_rx(err_rx), .mac_rst(mac_rst), .sys_rst(sys_rst)
  );

  typedef struct packed {
    logic rx;
    logic tx;
    logic ok;
    logic tmo;
  } vec_t;

  // clock enables, whether the reset completes, timeout bit afterwards
  localparam vec_t VEC [5] = '{
    '{1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic do_srst(output int busy_n, output int pulse_n, output int mism);
    wr(32'h1);
    busy_n = 0; pulse_n = 0; mism = 0;
    for (int i = 0; i < 600; i++) begin
      if (!host_rdata[0]) break;
      busy_n++;
      if (mac_rst) pulse_n++;
      if (mac_rst !== sys_rst) mism++;
      @(negedge clk);
    end
  endtask

  task automatic set_clocks(input logic rx, input logic tx);
    rx_on = rx; tx_on = tx;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int b, p, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(host_rdata == 32'h8001_0000, "R1", host_rdata, 32'h8001_0000);
    chk({mac_rst, sys_rst, err_tx, err_rx} == 4'b0, "R1",
        {mac_rst, sys_rst, err_tx, err_rx}, 0);

    // R7 write before any read is ignored
    wr(32'h1);
    b = 0;
    for (int i = 0; i < 8; i++) begin
      if (host_rdata[0] || mac_rst) b++;
      @(negedge clk);
    end
    chk(b == 0, "R7", b, 0);

    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;

    // table walk: R2 R3 R4 R5
    foreach (VEC[k]) begin
      set_clocks(VEC[k].rx, VEC[k].tx);
      do_srst(b, p, m);
      chk(host_rdata[0] == 1'b0 && b > 0, "R2", b, 1);
      chk(m == 0, "R3", m, 0);
      if (VEC[k].ok) begin
        chk(p == 4, "R3", p, 4);
        chk(b > 4 && b <= 260, "R3", b, 260);
      end else begin
        chk(p == 0, "R4", p, 0);
        chk(b == 256, "R4", b, 256);
      end
      chk(host_rdata[8] == VEC[k].tmo, "R5", host_rdata[8], VEC[k].tmo);
    end

    // R6 error flags
    @(negedge clk); err_tx_set = 1'b1; err_rx_set = 1'b1;
    @(negedge clk); err_tx_set = 1'b0; err_rx_set = 1'b0;
    chk(err_tx && err_rx, "R6", {err_tx, err_rx}, 3);
    set_clocks(1'b0, 1'b1);
    do_srst(b, p, m);
    chk(err_tx && err_rx, "R6", {err_tx, err_rx}, 3);
    set_clocks(1'b1, 1'b1);
    do_srst(b, p, m);
    chk(!err_tx && !err_rx, "R6", {err_tx, err_rx}, 0);

    // R8 strap and fixed bit
    strap_wide = 1'b0;
    wr(32'h0001_0000);
    chk(host_rdata[16] == 1'b0, "R8", host_rdata[16], 0);
    strap_wide = 1'b1;
    wr(32'h0000_0000);
    @(negedge clk);
    chk(host_rdata == 32'h8001_0000, "R8", host_rdata, 32'h8001_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule